// File: doc/BRIEF.md
# DMA Channel Request Scheduler

This block chooses, once per clock, which DMA channel may move one data element next. Each channel supplies its 32-bit configuration word and its 12-bit count of elements still to move. The block also sees the controller-wide configuration word and two 32-bit peripheral request vectors, one for single requests and one for burst requests. From these it decides which channels are eligible and grants the lowest-numbered one. The grant is presented as a registered valid flag plus a channel index.

A channel is eligible only if all of the following hold:
- the controller is enabled;
- the channel is enabled and not halted;
- its count is not zero;
- its flow type is one of the four memory/peripheral combinations this block supports;
- the peripheral request lines that flow type names are asserted.

Flow types that hand flow control to a peripheral are never serviced. For those the block raises a per-channel unsupported flag instead. Storing the channel registers and moving the data happen outside this block.

Priority is strictly by channel index. The lowest eligible channel wins every cycle, so a channel keeps the grant for as long as it stays eligible. Higher channels are served only after it drops out, for example when its count reaches zero or its request line falls.

Top module: `dma_req_sched`

## Requirements
- R1: No grant is issued unless bit 0 of `glb_cfg` is 1. The other bits of `glb_cfg` have no effect.
- R2: A channel can be granted only when bit 0 (enable) of its configuration word is 1 and bit 18 (halt) is 0.
- R3: The channel configuration word is decoded as follows:
  - bits 13:11 hold the flow type;
  - bits 5:1 hold the source peripheral number;
  - bits 10:6 hold the destination peripheral number.
  
  A peripheral number n refers to bit n of the request vector.
- R4: The request vector used for eligibility is the bitwise OR of `req_single` and `req_burst`.
- R5: Flow type 0 needs no request. Flow type 1 needs the destination peripheral's request bit. Flow type 2 needs the source peripheral's request bit. Flow type 3 needs both bits.
- R6: A channel whose 12-bit count is zero is never granted.
- R7: Flow types 4 to 7 are never granted. `unsup_mask[c]` is 1 exactly when channel c has bit 0 set and a flow type of 4 or more. This holds regardless of halt, count and the global enable.
- R8: The granted channel is the lowest-indexed eligible channel. `grant_vld`, `grant_idx` and `unsup_mask` are registered: they reflect the inputs sampled at the previous rising clock edge.
- R9: While `rst` is high at a clock edge, the outputs are cleared: `grant_vld` becomes 0, `grant_idx` becomes 0 and `unsup_mask` becomes 0.
- R10: Whenever `grant_vld` is 0, `grant_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| glb_cfg | input | 32 | Controller-wide configuration word; bit 0 is the enable |
| chan_cfg | input | NUM_CH*32 | Configuration words, channel c in bits [c*32 +: 32] |
| chan_cnt | input | NUM_CH*12 | Remaining element counts, channel c in bits [c*12 +: 12] |
| req_single | input | 32 | Single-transfer request lines, one per peripheral |
| req_burst | input | 32 | Burst request lines, one per peripheral |
| grant_vld | output | 1 | A channel is granted one element this cycle |
| grant_idx | output | $clog2(NUM_CH) | Index of the granted channel, 0 when no grant |
| unsup_mask | output | NUM_CH | Per-channel flag for an enabled peripheral-flow-controlled type |

## Verification
The bench targets the decode boundaries that a wrong design would get wrong in recognisable ways:
- A shifted field slice would test the wrong peripheral. The bench catches this with peripheral 31 and with a request on a neighbouring line.
- Ignoring the burst vector would stall channels that are woken only by burst requests.
- Treating flow type 3 as either-or would grant when only the source line is active.
- A count check, halt check or global-enable check that is missing would grant channels that should be idle. The bench sets every global bit except bit 0 to expose a missing enable check.

The priority and holding behaviour is checked with a second channel:
- A scan that rotates, or that starts from the highest index, would pick channel 5 over channel 1. It would also leave channel 0 when it should keep granting it across consecutive cycles.
- A flow type of 5 on a lower channel must raise its unsupported flag and never win the grant.

// File: rtl/dma_sched_pkg.sv
`timescale 1ns/1ps
package dma_sched_pkg;

    localparam int CFG_W       = 32;
    localparam int CNT_W       = 12;
    localparam int PERIPH_ID_W = 5;
    localparam int REQ_W       = 1 << PERIPH_ID_W;
    localparam int FLOW_W      = 3;

    localparam int BIT_EN       = 0;
    localparam int BIT_SRC_LO   = 1;
    localparam int BIT_DST_LO   = 6;
    localparam int BIT_FLOW_LO  = 11;
    localparam int BIT_HALT     = 18;
    localparam int BIT_GLB_EN   = 0;

    typedef enum logic [FLOW_W-1:0] {
        FLOW_MEM_MEM   = 3'd0,
        FLOW_MEM_PER   = 3'd1,
        FLOW_PER_MEM   = 3'd2,
        FLOW_PER_PER   = 3'd3,
        FLOW_PC_DST    = 3'd4,
        FLOW_PC_SRC    = 3'd5,
        FLOW_PC_BOTH   = 3'd6,
        FLOW_PC_OTHER  = 3'd7
    } flow_e;

    typedef struct packed {
        logic                   enable;
        logic                   halt;
        flow_e                  flow;
        logic [PERIPH_ID_W-1:0] src_id;
        logic [PERIPH_ID_W-1:0] dst_id;
    } chan_fields_t;

    typedef struct packed {
        logic need_src;
        logic need_dst;
        logic supported;
    } flow_needs_t;

    function automatic chan_fields_t decode_cfg(input logic [CFG_W-1:0] w);
        chan_fields_t f;
        f.enable = w[BIT_EN];
        f.halt   = w[BIT_HALT];
        f.flow   = flow_e'(w[BIT_FLOW_LO +: FLOW_W]);
        f.src_id = w[BIT_SRC_LO +: PERIPH_ID_W];
        f.dst_id = w[BIT_DST_LO +: PERIPH_ID_W];
        return f;
    endfunction

    function automatic flow_needs_t flow_needs(input flow_e fl);
        flow_needs_t n;
        n = '{need_src: 1'b0, need_dst: 1'b0, supported: 1'b0};
        case (fl)
            FLOW_MEM_MEM: n.supported = 1'b1;
            FLOW_MEM_PER: begin
                n.supported = 1'b1;
                n.need_dst  = 1'b1;
            end
            FLOW_PER_MEM: begin
                n.supported = 1'b1;
                n.need_src  = 1'b1;
            end
            FLOW_PER_PER: begin
                n.supported = 1'b1;
                n.need_src  = 1'b1;
                n.need_dst  = 1'b1;
            end
            default: n.supported = 1'b0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dma_req_merge.sv
`timescale 1ns/1ps
module dma_req_merge
    import dma_sched_pkg::*;
(
    input  logic [REQ_W-1:0] req_single,
    input  logic [REQ_W-1:0] req_burst,
    output logic [REQ_W-1:0] req_any
);

    for (genvar i = 0; i < REQ_W; i++) begin : g_line
        assign req_any[i] = req_single[i] | req_burst[i];
    end

endmodule

// File: rtl/dma_chan_eval.sv
`timescale 1ns/1ps
module dma_chan_eval
    import dma_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg,
    input  logic [CNT_W-1:0] count,
    input  logic [REQ_W-1:0] req_any,
    output logic             eligible,
    output logic             unsupported
);

    chan_fields_t fld;
    flow_needs_t  needs;
    logic         active;
    logic         src_ok;
    logic         dst_ok;
    logic         has_work;

    always_comb begin
        fld      = decode_cfg(cfg);
        needs    = flow_needs(fld.flow);
        active   = fld.enable & ~fld.halt;
        has_work = (count != '0);
        src_ok   = ~needs.need_src | req_any[fld.src_id];
        dst_ok   = ~needs.need_dst | req_any[fld.dst_id];
    end

    assign eligible    = active & has_work & needs.supported & src_ok & dst_ok;
    assign unsupported = fld.enable & ~needs.supported;

    // R6: a zero count never yields eligibility
    assert_zero_count_R6: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !eligible);

    // R2: halted or disabled channels are never eligible
    assert_halt_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg[BIT_HALT] || !cfg[BIT_EN]) |-> !eligible);

    // R7: an unsupported flow type is never eligible
    assert_unsup_no_elig_R7: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> !eligible);

endmodule

// File: rtl/dma_prio_pick.sv
`timescale 1ns/1ps
module dma_prio_pick #(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     win_oh
);

    logic [N-1:0] below_taken;

    // thermometer of "some lower request seen"
    assign below_taken[0] = 1'b0;
    for (genvar i = 1; i < N; i++) begin : g_therm
        assign below_taken[i] = below_taken[i-1] | req[i-1];
    end

    for (genvar i = 0; i < N; i++) begin : g_oh
        assign win_oh[i] = req[i] & ~below_taken[i];
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;

    // R8: at most one winner
    assert_single_winner_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_oh));

    // R8: nothing below the winner was requesting
    assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (rst)
        any |-> ((req & ((N'(1) << idx) - N'(1))) == '0) && req[idx]);

endmodule

// File: rtl/dma_req_sched.sv
`timescale 1ns/1ps
module dma_req_sched
    import dma_sched_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CFG_W-1:0]        glb_cfg,
    input  logic [NUM_CH*CFG_W-1:0] chan_cfg,
    input  logic [NUM_CH*CNT_W-1:0] chan_cnt,
    input  logic [REQ_W-1:0]        req_single,
    input  logic [REQ_W-1:0]        req_burst,
    output logic                    grant_vld,
    output logic [IDX_W-1:0]        grant_idx,
    output logic [NUM_CH-1:0]       unsup_mask
);

    logic [REQ_W-1:0]  req_any;
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] unsup;
    logic [NUM_CH-1:0] gated;
    logic [NUM_CH-1:0] win_oh;
    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic              ctl_on;

    dma_req_merge u_merge (
        .req_single (req_single),
        .req_burst  (req_burst),
        .req_any    (req_any)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dma_chan_eval u_eval (
            .clk         (clk),
            .rst         (rst),
            .cfg         (chan_cfg[c*CFG_W +: CFG_W]),
            .count       (chan_cnt[c*CNT_W +: CNT_W]),
            .req_any     (req_any),
            .eligible    (elig[c]),
            .unsupported (unsup[c])
        );
    end

    assign ctl_on = glb_cfg[BIT_GLB_EN];
    assign gated  = ctl_on ? elig : '0;

    dma_prio_pick #(.N(NUM_CH)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .req    (gated),
        .any    (pick_any),
        .idx    (pick_idx),
        .win_oh (win_oh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_vld  <= 1'b0;
            grant_idx  <= '0;
            unsup_mask <= '0;
        end else begin
            grant_vld  <= pick_any;
            grant_idx  <= pick_any ? pick_idx : '0;
            unsup_mask <= unsup;
        end
    end

    // R1: controller disabled means no grant in the following cycle
    assert_gate_off_R1: assert property (@(posedge clk) disable iff (rst)
        !glb_cfg[BIT_GLB_EN] |=> !grant_vld);

    // R10: index parks at zero without a grant
    assert_idx_parked_R10: assert property (@(posedge clk) disable iff (rst)
        !grant_vld |-> (grant_idx == '0));

    // R7: a flagged channel is never the one granted
    assert_unsup_not_granted_R7: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> !unsup_mask[grant_idx]);

    // R8: winner one-hot agrees with the reported index
    assert_pick_match_R8: assert property (@(posedge clk) disable iff (rst)
        pick_any |-> win_oh[pick_idx]);

endmodule

// File: tb/sim_dma_req_sched.sv
`timescale 1ns/1ps
module sim_dma_req_sched;

    localparam int NCH = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [31:0]     glb_cfg = '0;
    logic [NCH*32-1:0] chan_cfg = '0;
    logic [NCH*12-1:0] chan_cnt = '0;
    logic [31:0]     req_single = '0;
    logic [31:0]     req_burst = '0;
    logic            grant_vld;
    logic [2:0]      grant_idx;
    logic [NCH-1:0]  unsup_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_req_sched #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst(rst), .glb_cfg(glb_cfg), .chan_cfg(chan_cfg),
        .chan_cnt(chan_cnt), .req_single(req_single), .req_burst(req_burst),
        .grant_vld(grant_vld), .grant_idx(grant_idx), .unsup_mask(unsup_mask)
    );

    function automatic logic [31:0] mk(input bit en, input bit hlt,
                                       input int fl, input int src, input int dst);
        logic [31:0] w;
        w        = '0;
        w[0]     = en;
        w[5:1]   = 5'(src);
        w[10:6]  = 5'(dst);
        w[13:11] = 3'(fl);
        w[18]    = hlt;
        return w;
    endfunction

    typedef struct packed {
        logic [31:0] glb;
        logic [2:0]  ca;
        logic [31:0] cfga;
        logic [11:0] cnta;
        logic [2:0]  cb;
        logic [31:0] cfgb;
        logic [11:0] cntb;
        logic [31:0] rs;
        logic [31:0] rb;
        logic        ev;
        logic [2:0]  ei;
        logic [7:0]  eu;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        // R1: every global bit but bit 0
        '{32'hFFFF_FFFE, 3'd2, mk(1,0,0,0,0), 12'd5, 3'd0, 32'd0, 12'd0, 32'd0, 32'd0, 1'b0, 3'd0, 8'h00, 4'd1},
        // R2: enabled, memory to memory
        '{32'h1, 3'd2, mk(1,0,0,0,0), 12'd5, 3'd0, 32'd0, 12'd0, 32'd0, 32'd0, 1'b1, 3'd2, 8'h00, 4'd2},
        // R2: halted
        '{32'h1, 3'd2, mk(1,1,0,0,0), 12'd5, 3'd0, 32'd0, 12'd0, 32'd0, 32'd0, 1'b0, 3'd0, 8'h00, 4'd2},
        // R2: channel enable clear
        '{32'h1, 3'd2, mk(0,0,0,0,0), 12'd5, 3'd0, 32'd0, 12'd0, 32'd0, 32'd0, 1'b0, 3'd0, 8'h00, 4'd2},
        // R5: type 1 with destination request
        '{32'h1, 3'd4, mk(1,0,1,0,7), 12'd3, 3'd0, 32'd0, 12'd0, 32'h80, 32'd0, 1'b1, 3'd4, 8'h00, 4'd5},
        // R3: neighbouring line only
        '{32'h1, 3'd4, mk(1,0,1,0,7), 12'd3, 3'd0, 32'd0, 12'd0, 32'h40, 32'd0, 1'b0, 3'd0, 8'h00, 4'd3},
        // R4: burst line only
        '{32'h1, 3'd4, mk(1,0,1,0,7), 12'd3, 3'd0, 32'd0, 12'd0, 32'd0, 32'h80, 1'b1, 3'd4, 8'h00, 4'd4},
        // R5: type 2 with source request
        '{32'h1, 3'd3, mk(1,0,2,20,0), 12'd9, 3'd0, 32'd0, 12'd0, 32'd0, 32'h0010_0000, 1'b1, 3'd3, 8'h00, 4'd5},
        // R3: request matches destination field, type 2 wants source
        '{32'h1, 3'd3, mk(1,0,2,3,20), 12'd9, 3'd0, 32'd0, 12'd0, 32'h0010_0000, 32'd0, 1'b0, 3'd0, 8'h00, 4'd3},
        // R5: type 3 with source only
        '{32'h1, 3'd6, mk(1,0,3,3,9), 12'd2, 3'd0, 32'd0, 12'd0, 32'h8, 32'd0, 1'b0, 3'd0, 8'h00, 4'd5},
        // R4: type 3, source on single, destination on burst
        '{32'h1, 3'd6, mk(1,0,3,3,9), 12'd2, 3'd0, 32'd0, 12'd0, 32'h8, 32'h200, 1'b1, 3'd6, 8'h00, 4'd4},
        // R6: zero count
        '{32'h1, 3'd6, mk(1,0,0,0,0), 12'd0, 3'd0, 32'd0, 12'd0, 32'd0, 32'd0, 1'b0, 3'd0, 8'h00, 4'd6},
        // R6: full count
        '{32'h1, 3'd6, mk(1,0,0,0,0), 12'hFFF, 3'd0, 32'd0, 12'd0, 32'd0, 32'd0, 1'b1, 3'd6, 8'h00, 4'd6},
        // R8: channels 5 and 1 both eligible
        '{32'h1, 3'd5, mk(1,0,0,0,0), 12'd1, 3'd1, mk(1,0,0,0,0), 12'd1, 32'd0, 32'd0, 1'b1, 3'd1, 8'h00, 4'd8},
        // R7: channel 1 type 5, channel 6 eligible
        '{32'h1, 3'd6, mk(1,0,0,0,0), 12'd1, 3'd1, mk(1,0,5,0,0), 12'd4, 32'd0, 32'd0, 1'b1, 3'd6, 8'h02, 4'd7},
        // R7: type 7 with enable clear is not flagged
        '{32'h1, 3'd7, mk(1,0,0,0,0), 12'd1, 3'd0, mk(0,0,7,0,0), 12'd4, 32'd0, 32'd0, 1'b1, 3'd7, 8'h00, 4'd7},
        // R7: type 4 while halted is still flagged
        '{32'h1, 3'd3, mk(1,1,4,0,0), 12'd4, 3'd0, 32'd0, 12'd0, 32'd0, 32'd0, 1'b0, 3'd0, 8'h08, 4'd7},
        // R7: flag independent of global enable
        '{32'h0, 3'd1, mk(1,0,6,0,0), 12'd4, 3'd0, 32'd0, 12'd0, 32'd0, 32'd0, 1'b0, 3'd0, 8'h02, 4'd7},
        // R3: peripheral 31 at the top of both fields
        '{32'h1, 3'd2, mk(1,0,3,31,31), 12'd1, 3'd0, 32'd0, 12'd0, 32'h8000_0000, 32'd0, 1'b1, 3'd2, 8'h00, 4'd3}
    };

    task automatic check(input string tag, input logic ev, input logic [2:0] ei,
                         input logic [7:0] eu);
        checks++;
        if (grant_vld !== ev || grant_idx !== ei || unsup_mask !== eu) begin
            errors++;
            $display("FAIL %s: got vld=%0b idx=%0d unsup=%02h, expected vld=%0b idx=%0d unsup=%02h",
                     tag, grant_vld, grant_idx, unsup_mask, ev, ei, eu);
        end
    endtask

    task automatic clear_inputs();
        glb_cfg    = '0;
        chan_cfg   = '0;
        chan_cnt   = '0;
        req_single = '0;
        req_burst  = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state, with an eligible channel present
        @(negedge clk);
        glb_cfg = 32'h1;
        chan_cfg[0 +: 32] = mk(1,0,0,0,0);
        chan_cnt[0 +: 12] = 12'd3;
        @(negedge clk);
        check("R9 reset", 1'b0, 3'd0, 8'h00);
        rst = 1'b0;

        // table walk; outputs reflect the inputs of the edge between negedges
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            clear_inputs();
            glb_cfg = TBL[v].glb;
            chan_cfg[TBL[v].cb*32 +: 32] = TBL[v].cfgb;
            chan_cnt[TBL[v].cb*12 +: 12] = TBL[v].cntb;
            chan_cfg[TBL[v].ca*32 +: 32] = TBL[v].cfga;
            chan_cnt[TBL[v].ca*12 +: 12] = TBL[v].cnta;
            req_single = TBL[v].rs;
            req_burst  = TBL[v].rb;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TBL[v].rq, v), TBL[v].ev, TBL[v].ei, TBL[v].eu);
        end

        // R8: channel 0 holds the grant, then channel 4 takes over
        clear_inputs();
        glb_cfg = 32'h1;
        chan_cfg[0 +: 32]  = mk(1,0,0,0,0);
        chan_cnt[0 +: 12]  = 12'd3;
        chan_cfg[128 +: 32] = mk(1,0,2,9,0);
        chan_cnt[48 +: 12]  = 12'd3;
        req_burst = 32'h200;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 hold lowest", 1'b1, 3'd0, 8'h00);
        end
        chan_cnt[0 +: 12] = 12'd0;
        @(negedge clk);
        check("R8 next channel", 1'b1, 3'd4, 8'h00);
        // R4/R5: request dropped ends the grant next cycle
        req_burst = '0;
        @(negedge clk);
        check("R5 request gone", 1'b0, 3'd0, 8'h00);

        // R10: idle index parks at zero after a grant at index 7
        chan_cfg[224 +: 32] = mk(1,0,0,0,0);
        chan_cnt[84 +: 12]  = 12'd1;
        @(negedge clk);
        check("R10 grant 7", 1'b1, 3'd7, 8'h00);
        glb_cfg = 32'h0;
        @(negedge clk);
        check("R10 parked idx", 1'b0, 3'd0, 8'h00);

        // R9: reset clears outputs mid-operation
        glb_cfg = 32'h1;
        chan_cfg[32 +: 32] = mk(1,0,5,0,0);
        @(negedge clk);
        check("R9 before reset", 1'b1, 3'd7, 8'h02);
        rst = 1'b1;
        @(negedge clk);
        check("R9 during reset", 1'b0, 3'd0, 8'h00);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule